// File: doc/BRIEF.md
# Time-Triggered Time Mark Unit

This block keeps one programmable time mark for a time-triggered CAN controller and signals the moment the running cycle time reaches that mark. A host-side write port loads a 16-bit mark value and a 7-bit cycle code. The cycle code acts as a filter on the basic-cycle count. Its highest set bit picks a repeat period of 2, 4, 8, 16, 32 or 64 cycles. The bits below that one give the residue that the cycle count, taken modulo the period, must equal. A code of 0 or 1 lets every cycle qualify.

Host values reach the CAN clock domain through a toggle-request handshake. The request crosses through a two-flop synchronizer. The CAN side then captures the stable host registers and sends an acknowledge toggle back. While a transfer is in flight a lock flag is set, and any host write to the mark register is dropped. The lock is set in two cases: by every write to the operation-control register, and by a mark write made while the time-mark-control field of that register is not 00. A mark write made with that field at 00 is stored on the host side and is carried across only by a later operation-control write. On the CAN side, a tick strobe with a local time equal to the active mark, in a qualifying cycle, gives a one-cycle match pulse.

Top module: `tt_mark_unit`

## Requirements
- R1: After reset the lock reads 0, the active mark is 0x0000 and the active cycle code is 0, so a tick at local time 0 gives a match in any cycle.
- R2: `can_match` is a registered pulse. It is high for exactly the CAN cycle after an edge where `can_tick` was 1, `can_time` equalled the active mark and the cycle qualified. Otherwise it is 0.
- R3: A cycle code of 0b0000000 or 0b0000001 qualifies every cycle count from 0 to 63.
- R4: For a cycle code whose highest set bit is bit k (k from 1 to 6), a cycle qualifies only when (cycle count mod 2^k) equals (code mod 2^k).
- R5: A pulse on `host_wr_ctrl` makes `host_lock` read 1 on the next host cycle.
- R6: A mark write accepted while `host_tmc` is not 00 sets the lock. When `host_tmc` is 00, the lock stays 0 and the active mark and code on the CAN side stay unchanged.
- R7: While `host_lock` is 1, mark writes are ignored. Once the transfer finishes, the values written before the lock remain the active ones.
- R8: The lock clears by itself after the handoff, within 40 host cycles. From then on the CAN side matches on the values the host held when the transfer started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host register clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| host_wr_mark | input | 1 | Write strobe for the mark register |
| host_wr_ctrl | input | 1 | Pulse marking a write to the operation-control register |
| host_tmc | input | 2 | Current time-mark-control field of the operation-control register |
| host_wmark | input | 16 | Mark value to write |
| host_wcode | input | 7 | Cycle code to write |
| host_lock | output | 1 | Lock flag read-back; 1 means mark writes are blocked |
| can_clk | input | 1 | CAN-side clock |
| can_rst | input | 1 | Synchronous active-high reset, CAN domain |
| can_tick | input | 1 | Time-base tick strobe |
| can_time | input | 16 | Local time |
| can_cycle | input | 6 | Current basic-cycle count |
| can_match | output | 1 | One-cycle time-mark match pulse |

## Verification
The bench checks the filter at each period boundary. It uses codes with a residue at the top of the range, such as 0x7F against cycles 63 and 31. A design that decoded the wrong leading bit, or that compared too many residue bits, would match in the wrong cycles. The bench writes while the lock is held and with the control field at 00. A design that let either write through would match on the new mark, not the held one. The bench also waits for the lock to clear and then checks the new mark at once. A design that cleared the lock before the CAN capture would still match on the old mark at that point.

// File: rtl/tt_mark_pkg.sv
package tt_mark_pkg;
  localparam int MARK_W = 16;
  localparam int CODE_W = 7;
  localparam int CNT_W  = CODE_W - 1;
  localparam logic [1:0] TMC_OFF = 2'b00;
endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tt_cycle_filter.sv
module tt_cycle_filter #(
  parameter int CODE_W = 7,
  parameter int CNT_W  = CODE_W - 1
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CNT_W-1:0]  cycle,
  output logic              valid
);
  logic [CNT_W-1:0] mask;

  // mask covers every bit below the leading one of the code
  always_comb begin
    mask = '0;
    for (int i = 1; i < CODE_W; i++)
      if (code[i]) mask = CNT_W'((1 << i) - 1);
    valid = ((cycle ^ code[CNT_W-1:0]) & mask) == '0;
  end
endmodule

// File: rtl/tt_host_regs.sv
module tt_host_regs #(
  parameter int MARK_W = 16,
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mark,
  input  logic              wr_ctrl,
  input  logic [1:0]        tmc,
  input  logic [MARK_W-1:0] wmark,
  input  logic [CODE_W-1:0] wcode,
  input  logic              ack_tgl,
  output logic [MARK_W-1:0] mark_q,
  output logic [CODE_W-1:0] code_q,
  output logic              req_q,
  output logic              lock_q
);
  import tt_mark_pkg::*;

  logic ack_s;
  logic start;
  logic done;

  tt_sync #(.W(1), .STAGES(2)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_s)
  );

  assign start = !lock_q && (wr_ctrl || (wr_mark && tmc != TMC_OFF));
  assign done  = lock_q && (ack_s == req_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q <= '0;
      code_q <= '0;
      req_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (wr_mark && !lock_q) begin
        mark_q <= wmark;
        code_q <= wcode;
      end
      if (start) begin
        req_q  <= ~req_q;
        lock_q <= 1'b1;
      end else if (done) begin
        lock_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tt_mark_unit.sv
module tt_mark_unit #(
  parameter int MARK_W = tt_mark_pkg::MARK_W,
  parameter int CODE_W = tt_mark_pkg::CODE_W,
  parameter int CNT_W  = CODE_W - 1
) (
  input  logic              host_clk,
  input  logic              host_rst,
  input  logic              host_wr_mark,
  input  logic              host_wr_ctrl,
  input  logic [1:0]        host_tmc,
  input  logic [MARK_W-1:0] host_wmark,
  input  logic [CODE_W-1:0] host_wcode,
  output logic              host_lock,
  input  logic              can_clk,
  input  logic              can_rst,
  input  logic              can_tick,
  input  logic [MARK_W-1:0] can_time,
  input  logic [CNT_W-1:0]  can_cycle,
  output logic              can_match
);
  logic [MARK_W-1:0] h_mark;
  logic [CODE_W-1:0] h_code;
  logic              h_req;
  logic              req_s;
  logic              ack_q;
  logic [MARK_W-1:0] act_mark;
  logic [CODE_W-1:0] act_code;
  logic              cyc_ok;

  tt_host_regs #(.MARK_W(MARK_W), .CODE_W(CODE_W)) u_host (
    .clk(host_clk), .rst(host_rst),
    .wr_mark(host_wr_mark), .wr_ctrl(host_wr_ctrl), .tmc(host_tmc),
    .wmark(host_wmark), .wcode(host_wcode), .ack_tgl(ack_q),
    .mark_q(h_mark), .code_q(h_code), .req_q(h_req), .lock_q(host_lock)
  );

  tt_sync #(.W(1), .STAGES(2)) u_req_sync (
    .clk(can_clk), .rst(can_rst), .d(h_req), .q(req_s)
  );

  // host values are held by the lock while the request is pending
  always_ff @(posedge can_clk) begin
    if (can_rst) begin
      ack_q    <= 1'b0;
      act_mark <= '0;
      act_code <= '0;
    end else if (req_s != ack_q) begin
      ack_q    <= req_s;
      act_mark <= h_mark;
      act_code <= h_code;
    end
  end

  tt_cycle_filter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_filt (
    .code(act_code), .cycle(can_cycle), .valid(cyc_ok)
  );

  always_ff @(posedge can_clk) begin
    if (can_rst) can_match <= 1'b0;
    else         can_match <= can_tick && (can_time == act_mark) && cyc_ok;
  end
endmodule

// File: rtl/tt_mark_unit_chk.sv
module tt_mark_unit_chk #(
  parameter int MARK_W = 16,
  parameter int CODE_W = 7
) (
  input logic              host_clk,
  input logic              host_rst,
  input logic              host_wr_mark,
  input logic              host_wr_ctrl,
  input logic [1:0]        host_tmc,
  input logic              host_lock,
  input logic [MARK_W-1:0] h_mark,
  input logic [CODE_W-1:0] h_code,
  input logic              can_clk,
  input logic              can_rst,
  input logic              can_tick,
  input logic              can_match,
  input logic              req_s,
  input logic              ack_q,
  input logic [MARK_W-1:0] act_mark
);
  // R5
  ctrl_sets_lock_chk: assert property (@(posedge host_clk) disable iff (host_rst)
    host_wr_ctrl |=> host_lock);

  // R7
  locked_hold_chk: assert property (@(posedge host_clk) disable iff (host_rst)
    host_lock |=> ($stable(h_mark) && $stable(h_code)));

  // R6
  quiet_write_chk: assert property (@(posedge host_clk) disable iff (host_rst)
    (host_wr_mark && !host_wr_ctrl && host_tmc == 2'b00 && !host_lock) |=> !host_lock);

  // R8
  act_update_chk: assert property (@(posedge can_clk) disable iff (can_rst)
    !$stable(act_mark) |-> $past(req_s != ack_q));

  // R2
  match_tick_chk: assert property (@(posedge can_clk) disable iff (can_rst)
    can_match |-> $past(can_tick));
endmodule

bind tt_mark_unit tt_mark_unit_chk #(.MARK_W(MARK_W), .CODE_W(CODE_W)) u_chk (
  .host_clk(host_clk), .host_rst(host_rst), .host_wr_mark(host_wr_mark),
  .host_wr_ctrl(host_wr_ctrl), .host_tmc(host_tmc), .host_lock(host_lock),
  .h_mark(h_mark), .h_code(h_code), .can_clk(can_clk), .can_rst(can_rst),
  .can_tick(can_tick), .can_match(can_match), .req_s(req_s), .ack_q(ack_q),
  .act_mark(act_mark)
);

// File: tb/tt_mark_unit_tb.sv
module tt_mark_unit_tb;
  logic        host_clk = 0, can_clk = 0;
  logic        host_rst = 1, can_rst = 1;
  logic        host_wr_mark = 0, host_wr_ctrl = 0;
  logic [1:0]  host_tmc = 0;
  logic [15:0] host_wmark = 0;
  logic [6:0]  host_wcode = 0;
  logic        host_lock;
  logic        can_tick = 0;
  logic [15:0] can_time = 0;
  logic [5:0]  can_cycle = 0;
  logic        can_match;

  int checks = 0, fails = 0;
  logic [15:0] ref_mark = 0;
  logic [6:0]  ref_code = 0;

  always #5 host_clk = ~host_clk;
  always #7 can_clk = ~can_clk;

  tt_mark_unit u_dut (.*);

  function automatic bit qual(input logic [6:0] code, input logic [5:0] cyc);
    int k = 0;
    for (int i = 6; i >= 1; i--) if (code[i] && k == 0) k = i;
    if (k == 0) return 1'b1;
    return (int'(cyc) % (1 << k)) == (int'(code) % (1 << k));
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic hwrite(input bit wm, input bit wc, input logic [1:0] tmc,
                        input logic [15:0] m, input logic [6:0] c);
    @(negedge host_clk);
    host_wr_mark = wm; host_wr_ctrl = wc; host_tmc = tmc;
    host_wmark = m; host_wcode = c;
    @(negedge host_clk);
    host_wr_mark = 0; host_wr_ctrl = 0;
  endtask

  task automatic wait_unlock(input string req);
    int n = 0;
    while (host_lock && n < 40) begin @(negedge host_clk); n++; end
    check(req, host_lock, 1'b0);
  endtask

  task automatic probe(input string req, input bit tk, input logic [15:0] t,
                       input logic [5:0] cyc, input logic exp);
    @(negedge can_clk);
    can_tick = tk; can_time = t; can_cycle = cyc;
    @(negedge can_clk);
    can_tick = 0;
    check(req, can_match, exp);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd2417);
    repeat (4) @(negedge can_clk);
    host_rst = 0; can_rst = 0;
    @(negedge host_clk);
    check("R1 lock", host_lock, 1'b0);
    probe("R1 mark0", 1, 16'h0000, 6'd37, 1'b1);
    probe("R2 no tick", 0, 16'h0000, 6'd0, 1'b0);

    // quiet write: stored, not transferred
    hwrite(1, 0, 2'b00, 16'h1234, 7'd0);
    check("R6 tmc00 no lock", host_lock, 1'b0);
    repeat (10) @(negedge host_clk);
    probe("R6 old mark kept", 1, 16'h0000, 6'd3, 1'b1);
    probe("R6 new mark inactive", 1, 16'h1234, 6'd3, 1'b0);

    hwrite(0, 1, 2'b00, 16'h0, 7'd0);
    check("R5 ctrl lock", host_lock, 1'b1);
    hwrite(1, 0, 2'b01, 16'hBEEF, 7'd0);
    check("R7 lock held", host_lock, 1'b1);
    wait_unlock("R8 unlock");
    probe("R8 new mark", 1, 16'h1234, 6'd9, 1'b1);
    probe("R7 ignored write", 1, 16'hBEEF, 6'd9, 1'b0);
    probe("R2 time miss", 1, 16'h1235, 6'd9, 1'b0);

    hwrite(1, 0, 2'b10, 16'h00FF, 7'b0001101);
    check("R6 tmc set lock", host_lock, 1'b1);
    wait_unlock("R8 unlock2");
    probe("R4 mod8 c5", 1, 16'h00FF, 6'd5, 1'b1);
    probe("R4 mod8 c13", 1, 16'h00FF, 6'd13, 1'b1);
    probe("R4 mod8 c4", 1, 16'h00FF, 6'd4, 1'b0);
    probe("R4 mod8 c6", 1, 16'h00FF, 6'd6, 1'b0);

    hwrite(1, 0, 2'b11, 16'h00FF, 7'h7F);
    wait_unlock("R8 unlock3");
    probe("R4 mod64 c63", 1, 16'h00FF, 6'd63, 1'b1);
    probe("R4 mod64 c31", 1, 16'h00FF, 6'd31, 1'b0);

    hwrite(1, 0, 2'b01, 16'h4000, 7'd1);
    wait_unlock("R8 unlock4");
    for (int c = 0; c < 64; c += 9) probe("R3 all cycles", 1, 16'h4000, 6'(c), 1'b1);

    ref_mark = 16'h4000; ref_code = 7'd1;
    for (int it = 0; it < 40; it++) begin
      logic [15:0] m = 16'($urandom);
      logic [6:0]  c = 7'($urandom);
      if (($urandom % 2) == 0) begin
        hwrite(1, 0, 2'(1 + $urandom % 3), m, c);
        check("R6 rand lock", host_lock, 1'b1);
      end else begin
        hwrite(1, 0, 2'b00, m, c);
        hwrite(0, 1, 2'b00, 16'h0, 7'd0);
        check("R5 rand lock", host_lock, 1'b1);
      end
      hwrite(1, 0, 2'b01, ~m, ~c);
      wait_unlock("R8 rand unlock");
      ref_mark = m; ref_code = c;
      for (int p = 0; p < 8; p++) begin
        bit tk = ($urandom % 4) != 0;
        logic [15:0] t = (($urandom % 3) != 0) ? ref_mark : 16'($urandom);
        logic [5:0] cy = 6'($urandom);
        probe("R2/R4 rand", tk, t, cy, tk && (t == ref_mark) && qual(ref_code, cy));
      end
    end
    if (seed == 0) $display("seed zero");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule